// File: doc/BRIEF.md
# Single-Channel Byte Mover Between Memory Bus and Peripheral Bus

This block is one channel of a direct memory access engine. It copies a run of bytes between a 24-bit memory bus address (a 16-bit offset plus an 8-bit bank) and an 8-bit peripheral register address. Software sets up the channel through a small byte-wide register port and then pulses `start`. The channel drives both bus ports at the same time. A byte moves in any cycle where both sides acknowledge. So with both acknowledges held high, the channel moves one byte per clock.

Four settings define a transfer:
- the direction of the copy;
- how the memory offset moves after each byte: it stays fixed, counts up or counts down, and it wraps inside 16 bits without touching the bank;
- a repeating peripheral offset pattern, which is added to the peripheral base and lets one run feed single, paired or four-wide register groups;
- a 16-bit byte count.

While the run is active, `busy` is high. When the run ends, `done` pulses, the count register reads zero and the memory offset register holds its final stepped value.

Top module: `bus_dma_channel`

## Requirements
- R1: The register port has seven byte registers, read combinationally on `cfgRdata` at `cfgAddr`. They are: 0 control, 1 peripheral base, 2 memory offset low, 3 memory offset high, 4 bank, 5 count low, 6 count high. Any other address reads 0. Writes take effect at the clock edge while `busy` is low. Writes made while `busy` is high are ignored.
- R2: A `start` pulse with `busy` low raises `busy` in the next cycle. `memReq` and `perReq` are high exactly while `busy` is high.
- R3: Control bit 7 = 0 copies memory to peripheral: `perWe`=1, `memWe`=0, and `perWdata` carries `memRdata`.
- R4: Control bit 7 = 1 copies peripheral to memory: `memWe`=1, `perWe`=0, and `memWdata` carries `perRdata`.
- R5: A byte is taken only in a cycle where `memAck` and `perAck` are both high. In any other cycle, both addresses and the count hold.
- R6: After each byte, the 16-bit memory offset is unchanged if control bit 3 = 1. If bit 3 = 0, it changes by +1 when control bit 4 = 0 and by -1 when bit 4 = 1. It wraps modulo 65536, and the bank byte (`memAddr[23:16]`) never changes.
- R7: The peripheral address for byte k (counting from 0) is the base plus an offset set by control bits 2:0. Modes 0, 2 and 6 give 0. Modes 1 and 5 give k mod 2. Modes 3 and 7 give (k/2) mod 2. Mode 4 gives k mod 4. The sum wraps at 8 bits.
- R8: A transfer moves exactly the number of bytes in the count register. A count of 0 moves 65536 bytes.
- R9: After the last byte is taken, `busy` is low and `done` is high for exactly one cycle. Afterwards, the count reads 0, the offset reads its start value stepped once per byte, and the bank and base are unchanged.
- R10: A `start` pulse while `busy` is high is ignored: no second run follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write enable |
| cfgAddr | input | 3 | Register select |
| cfgWdata | input | 8 | Register write data |
| cfgRdata | output | 8 | Register read data |
| start | input | 1 | Launch strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| memReq | output | 1 | Memory bus request |
| memWe | output | 1 | Memory bus write |
| memAddr | output | 24 | Memory bus address, bank in bits 23:16 |
| memWdata | output | 8 | Memory bus write data |
| memRdata | input | 8 | Memory bus read data |
| memAck | input | 1 | Memory bus accepts the current byte |
| perReq | output | 1 | Peripheral bus request |
| perWe | output | 1 | Peripheral bus write |
| perAddr | output | 8 | Peripheral register address |
| perWdata | output | 8 | Peripheral write data |
| perRdata | input | 8 | Peripheral read data |
| perAck | input | 1 | Peripheral bus accepts the current byte |

## Verification
A wrong pattern phase or a wrong offset step shows on `perAddr` or `memAddr` in the cycle of the next accepted byte. The bench compares both addresses and the routed data in every active cycle, so such an error is caught within one byte. A wrong count shows up as `done` arriving a byte early or late, and the count readback that follows the run exposes it. Random stalls on both acknowledges test that state holds in idle cycles. A write or start made in the middle of a run, followed by readback, tests that these are ignored.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef struct packed {
    logic launch;   // run begins at this edge
    logic advance;  // one byte taken at this edge
    logic finish;   // last byte taken at this edge
  } dmaStrobes_t;

  localparam logic [2:0] REG_CTRL    = 3'd0;
  localparam logic [2:0] REG_PBASE   = 3'd1;
  localparam logic [2:0] REG_OFS_LO  = 3'd2;
  localparam logic [2:0] REG_OFS_HI  = 3'd3;
  localparam logic [2:0] REG_BANK    = 3'd4;
  localparam logic [2:0] REG_CNT_LO  = 3'd5;
  localparam logic [2:0] REG_CNT_HI  = 3'd6;

  localparam int CTRL_DIR_BIT  = 7;
  localparam int CTRL_DEC_BIT  = 4;
  localparam int CTRL_HOLD_BIT = 3;

endpackage

// File: rtl/dma_offset_gen.sv
module dma_offset_gen #(
  parameter int PHASE_W = 2
) (
  input  logic [2:0]         mode,
  input  logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-1:0] offset
);
  // Pattern is a function of the byte phase; aliases fold upper modes.
  always_comb begin
    unique case (mode)
      3'd1, 3'd5: offset = PHASE_W'(phase[0]);
      3'd3, 3'd7: offset = PHASE_W'(phase[1]);
      3'd4:       offset = phase;
      default:    offset = '0;
    endcase
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        beatOk,
  input  logic        lastBeat,
  output logic        busy,
  output logic        done,
  output dmaStrobes_t strb
);
  always_comb begin
    strb.launch  = !busy && startReq;
    strb.advance = busy && beatOk;
    strb.finish  = busy && beatOk && lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.launch)      busy <= 1'b1;
      else if (strb.finish) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_chan_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [2:0]         cfgAddr,
  input  logic [REG_W-1:0]   cfgWdata,
  output logic [REG_W-1:0]   cfgRdata,
  input  logic               busy,
  input  dmaStrobes_t        strb,
  output logic [3*REG_W-1:0] memAddr,
  output logic [REG_W-1:0]   perAddr,
  output logic               dirToMem,
  output logic               lastBeat
);
  localparam int WORD_W = 2 * REG_W;

  logic [REG_W-1:0]   ctrlReg;
  logic [REG_W-1:0]   perBase;
  logic [WORD_W-1:0]  srcOfs;
  logic [REG_W-1:0]   srcBank;
  logic [WORD_W-1:0]  byteCnt;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] patOfs;
  logic               cfgOpen;

  assign cfgOpen = cfgWe && !busy;

  dma_offset_gen #(.PHASE_W(PHASE_W)) u_pat (
    .mode  (ctrlReg[2:0]),
    .phase (phase),
    .offset(patOfs)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      perBase <= '0;
      srcOfs  <= '0;
      srcBank <= '0;
      byteCnt <= '0;
      phase   <= '0;
    end else begin
      if (cfgOpen) begin
        unique case (cfgAddr)
          REG_CTRL:   ctrlReg              <= cfgWdata;
          REG_PBASE:  perBase              <= cfgWdata;
          REG_OFS_LO: srcOfs[REG_W-1:0]    <= cfgWdata;
          REG_OFS_HI: srcOfs[WORD_W-1:REG_W] <= cfgWdata;
          REG_BANK:   srcBank              <= cfgWdata;
          REG_CNT_LO: byteCnt[REG_W-1:0]   <= cfgWdata;
          REG_CNT_HI: byteCnt[WORD_W-1:REG_W] <= cfgWdata;
          default: ;
        endcase
      end
      if (strb.launch) phase <= '0;
      if (strb.advance) begin
        phase   <= phase + 1'b1;
        byteCnt <= byteCnt - 1'b1;
        if (!ctrlReg[CTRL_HOLD_BIT])
          srcOfs <= ctrlReg[CTRL_DEC_BIT] ? srcOfs - 1'b1 : srcOfs + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (cfgAddr)
      REG_CTRL:   cfgRdata = ctrlReg;
      REG_PBASE:  cfgRdata = perBase;
      REG_OFS_LO: cfgRdata = srcOfs[REG_W-1:0];
      REG_OFS_HI: cfgRdata = srcOfs[WORD_W-1:REG_W];
      REG_BANK:   cfgRdata = srcBank;
      REG_CNT_LO: cfgRdata = byteCnt[REG_W-1:0];
      REG_CNT_HI: cfgRdata = byteCnt[WORD_W-1:REG_W];
      default:    cfgRdata = '0;
    endcase
  end

  assign memAddr  = {srcBank, srcOfs};
  assign perAddr  = perBase + REG_W'(patOfs);
  assign dirToMem = ctrlReg[CTRL_DIR_BIT];
  assign lastBeat = (byteCnt == WORD_W'(1));
endmodule

// File: rtl/bus_dma_channel.sv
module bus_dma_channel
  import dma_chan_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int PHASE_W = 2,
  localparam int MEM_W  = 3 * REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             memReq,
  output logic             memWe,
  output logic [MEM_W-1:0] memAddr,
  output logic [REG_W-1:0] memWdata,
  input  logic [REG_W-1:0] memRdata,
  input  logic             memAck,
  output logic             perReq,
  output logic             perWe,
  output logic [REG_W-1:0] perAddr,
  output logic [REG_W-1:0] perWdata,
  input  logic [REG_W-1:0] perRdata,
  input  logic             perAck
);
  dmaStrobes_t strb;
  logic        dirToMem;
  logic        lastBeat;

  dma_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(start),
    .beatOk  (memAck && perAck),
    .lastBeat(lastBeat),
    .busy    (busy),
    .done    (done),
    .strb    (strb)
  );

  dma_datapath #(.REG_W(REG_W), .PHASE_W(PHASE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata),
    .busy    (busy),
    .strb    (strb),
    .memAddr (memAddr),
    .perAddr (perAddr),
    .dirToMem(dirToMem),
    .lastBeat(lastBeat)
  );

  assign memReq   = busy;
  assign perReq   = busy;
  assign memWe    = busy && dirToMem;
  assign perWe    = busy && !dirToMem;
  assign memWdata = perRdata;
  assign perWdata = memRdata;
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             memReq,
  input logic             perReq,
  input logic             memAck,
  input logic             perAck,
  input logic [3*REG_W-1:0] memAddr,
  input logic [REG_W-1:0] perAddr
);
  // R2: buses stay quiet outside a run
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !perReq));

  // R2: a launch raises busy next cycle
  p_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R5: no acceptance means nothing moves
  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(memAck && perAck)) |=> ($stable(memAddr) && $stable(perAddr)));

  // R6: bank byte untouched by stepping
  p_bank_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(memAddr[3*REG_W-1:2*REG_W]));

  // R9: done lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done only right after a run ends
  p_done_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

bind bus_dma_channel dma_chan_checker #(.REG_W(REG_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .memReq (memReq),
  .perReq (perReq),
  .memAck (memAck),
  .perAck (perAck),
  .memAddr(memAddr),
  .perAddr(perAddr)
);

// File: tb/bus_dma_channel_test.sv
`timescale 1ns/1ps
module bus_dma_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        start = 1'b0;
  logic        busy, done;
  logic        memReq, memWe, perReq, perWe;
  logic [23:0] memAddr;
  logic [7:0]  memWdata, memRdata, perAddr, perWdata, perRdata;
  logic        memAck = 1'b0, perAck = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bus_dma_channel uut (.*);

  function automatic logic [7:0] memFn(input logic [23:0] a);
    return (a[7:0] * 8'd7 + a[15:8]) ^ a[23:16];
  endfunction
  function automatic logic [7:0] perFn(input logic [7:0] p);
    return p ^ 8'h5A;
  endfunction
  function automatic int expOff(input logic [2:0] mode, input int k);
    case (mode)
      3'd1, 3'd5: return k % 2;
      3'd3, 3'd7: return (k / 2) % 2;
      3'd4:       return k % 4;
      default:    return 0;
    endcase
  endfunction

  assign memRdata = memFn(memAddr);
  assign perRdata = perFn(perAddr);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    cfgAddr = a;
    #1 v = cfgRdata;
    @(negedge clk);
  endtask

  task automatic runXfer(input logic [7:0] ctrl, input logic [7:0] base,
                         input logic [15:0] ofs, input logic [7:0] bank,
                         input logic [15:0] cnt, input bit randAck,
                         input bit poke);
    int n, idx, v, lo, hi;
    logic [15:0] eOfs;
    logic [23:0] eMem;
    logic [7:0]  ePer;
    bit poked;
    wr(3'd0, ctrl); wr(3'd1, base); wr(3'd2, ofs[7:0]); wr(3'd3, ofs[15:8]);
    wr(3'd4, bank); wr(3'd5, cnt[7:0]); wr(3'd6, cnt[15:8]);
    n = (cnt == 16'd0) ? 65536 : int'(cnt);
    eOfs = ofs; idx = 0; poked = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", int'(busy), 1);
    while (idx < n) begin
      cfgWe = 1'b0; start = 1'b0;
      eMem = {bank, eOfs};
      ePer = base + 8'(expOff(ctrl[2:0], idx));
      chk("R2 memReq while busy", int'(memReq && perReq && busy), 1);
      chk("R6 memAddr", int'(memAddr), int'(eMem));
      chk("R7 perAddr", int'(perAddr), int'(ePer));
      if (!ctrl[7]) begin
        chk("R3 write enables", int'({memWe, perWe}), 1);
        chk("R3 perWdata", int'(perWdata), int'(memFn(eMem)));
      end else begin
        chk("R4 write enables", int'({memWe, perWe}), 2);
        chk("R4 memWdata", int'(memWdata), int'(perFn(ePer)));
      end
      if (poke && !poked && idx == n / 2) begin
        poked = 1;
        cfgWe = 1'b1; cfgAddr = 3'd0; cfgWdata = ~ctrl; start = 1'b1;
      end
      if (randAck) begin
        memAck = ($urandom % 4) != 0;
        perAck = ($urandom % 4) != 0;
      end else begin
        memAck = 1'b1; perAck = 1'b1;
      end
      if (memAck && perAck) begin
        idx++;
        if (!ctrl[3]) eOfs = ctrl[4] ? eOfs - 16'd1 : eOfs + 16'd1;
      end
      @(negedge clk);
    end
    memAck = 1'b0; perAck = 1'b0; cfgWe = 1'b0; start = 1'b0;
    chk("R9 busy low at end", int'(busy), 0);
    chk("R9 done pulse", int'(done), 1);
    chk("R8 byte count honoured", idx, n);
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
    chk("R10 no second run", int'(busy), 0);
    rd(3'd5, lo); rd(3'd6, hi);
    chk("R9 count reads zero", (hi << 8) | lo, 0);
    rd(3'd2, lo); rd(3'd3, hi);
    chk("R9 R6 final offset", (hi << 8) | lo, int'(eOfs));
    rd(3'd4, v);
    chk("R6 bank unchanged", v, int'(bank));
    rd(3'd1, v);
    chk("R9 base unchanged", v, int'(base));
    rd(3'd0, v);
    chk("R1 ctrl write during run ignored", v, int'(ctrl));
  endtask

  initial begin
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 reset busy", int'(busy), 0);
    chk("R9 reset done", int'(done), 0);
    chk("R2 reset requests", int'(memReq || perReq), 0);
    rd(3'd6, v);
    chk("R1 reset count high", v, 0);
    wr(3'd1, 8'hA5);
    rd(3'd1, v);
    chk("R1 base readback", v, 8'hA5);
    rd(3'd7, v);
    chk("R1 unused address reads 0", v, 0);

    // directed corner cases
    runXfer(8'h00, 8'h18, 16'h1000, 8'h7E, 16'd7, 1'b0, 1'b1); // mode 0, incr
    runXfer(8'h14, 8'hFE, 16'h0002, 8'h01, 16'd9, 1'b1, 1'b1); // mode 4, decr, wraps offset and base
    runXfer(8'h0B, 8'h22, 16'hFFFE, 8'h33, 16'd6, 1'b1, 1'b0); // mode 3, hold
    runXfer(8'h81, 8'h40, 16'hFFFD, 8'hC0, 16'd8, 1'b1, 1'b1); // to memory, mode 1, incr wrap
    runXfer(8'h05, 8'h10, 16'h0100, 8'h02, 16'd5, 1'b0, 1'b0); // alias mode 5
    runXfer(8'h87, 8'h10, 16'h0200, 8'h02, 16'd8, 1'b1, 1'b0); // alias mode 7
    runXfer(8'h06, 8'h10, 16'h0300, 8'h02, 16'd3, 1'b0, 1'b0); // alias mode 6
    runXfer(8'h02, 8'h21, 16'h8000, 8'h00, 16'd1, 1'b1, 1'b0); // single byte
    runXfer(8'h02, 8'h18, 16'h0000, 8'h7F, 16'd0, 1'b0, 1'b0); // count 0 -> 65536

    // constrained random runs
    for (int r = 0; r < 10; r++) begin
      logic [7:0] c;
      c = 8'($urandom) & 8'h9F;
      runXfer(c, 8'($urandom), 16'($urandom), 8'($urandom),
              16'(1 + $urandom % 40), 1'b1, 1'(r % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule